// File: doc/BRIEF.md
# Circular Cell-Write Sequencer

This block is a cycle-level digital model of a circular write sequencer for a bank of analog storage cells. One clock tick stands for one cell. A rising edge on the run input starts a wave at cell 0. The wave then moves forward one cell per clock. In continuous mode it goes round the ring without end. In single-shot mode it stops after the last cell. A tap output changes state whenever the wave arrives at the middle cell of the ring, so an external loop can measure the revolution rate.

A write input decides whether the cells are really being written. A separate channel-activation register moves by one position for each revolution completed while writing. This lets eight physical channels be joined into fewer, deeper virtual channels. Which channels join depends on the pattern loaded into the register: 0xFF, 0x55, 0x11 or 0x01. The bit that leaves the register appears on a chain output. The bit that enters is either the leaving bit or an external chain input, as chosen by a loop select.

The block also records the cell where writing stopped. It raises a sticky error flag when the run input is dropped too soon after the write input.

Top module: `ring_seq_top`

## Requirements
- R1: One clock after run_en is seen rising, `running` is 1 and `cell_idx` is 0. After that, `cell_idx` rises by one per clock. On the first clock where run_en is seen low, `running` clears and `cell_idx` holds its value.
- R2: `tap` is 0 after reset. It inverts on the clock where `cell_idx` becomes CELLS/2, which is 512, and changes at no other time.
- R3: With cont_mode=1, the cell after CELLS-1 (1023) is 0. With cont_mode=0, the wave halts at 1023: `running` clears and `cell_idx` stays at 1023. In this mode `tap` makes only one low-to-high change from reset.
- R4: `ch_active[i]` for i<8 equals activation bit i AND wcfg[i] AND `running` AND wr_en. `ch_active[8]` equals `running` AND wr_en and does not depend on either register.
- R5: The activation register resets to all ones. It shifts toward the MSB by one place on the clock where a running wave leaves cell 1023, but only while run_en and wr_en are both high.
- R6: `chain_out` is activation bit 7. The bit shifted into bit 0 is bit 7 when loop_sel=1 and chain_in when loop_sel=0.
- R7: act_load=1 copies act_init into the activation register. If a shift falls on the same clock, the load wins.
- R8: When wr_en is seen low for the first clock during a run, `stop_pos` takes the `cell_idx` value of that clock. It is 0 after reset.
- R9: `seq_err` is set, and stays set until reset, if run_en falls during a run while wr_en is still high, or fewer than guard_cyc clocks after wr_en fell.
- R10: After reset: `running`=0, `cell_idx`=0, `stop_pos`=0, `seq_err`=0, `ch_active`=0 and `chain_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Starts the wave on a rising edge, stops it when low |
| wr_en | input | 1 | Writing of cells allowed |
| cont_mode | input | 1 | 1 continuous ring, 0 single pass |
| loop_sel | input | 1 | 1 feeds back bit 7, 0 takes chain_in |
| chain_in | input | 1 | External bit entering the activation register |
| act_load | input | 1 | Parallel load strobe for the activation register |
| act_init | input | 8 | Pattern to load |
| wcfg | input | 8 | Per-channel write-config mask |
| guard_cyc | input | 4 | Minimum clocks from write fall to run fall |
| running | output | 1 | Wave in motion |
| cell_idx | output | 10 | Current cell |
| tap | output | 1 | Mid-ring toggle |
| ch_active | output | 9 | Per-channel write activity, bit 8 is the always-on channel |
| chain_out | output | 1 | Bit leaving the activation register |
| stop_pos | output | 10 | Cell captured at write stop |
| seq_err | output | 1 | Sticky ordering violation |

## Verification
A parallel load of the activation register can land on the same clock as the end-of-revolution shift. To provoke this, the bench raises act_load while `cell_idx` shows 1023, so that both the load and the shift fall on the wrap edge. The bench then expects the loaded pattern itself, not the shifted one, on the following cell 0. It also expects that pattern to shift normally one revolution later. The start of a run and the first writing cycle also coincide, and the bench judges this through `ch_active` on cell 0.

// File: rtl/ring_seq_pkg.sv
package ring_seq_pkg;
  typedef enum logic {WAVE_IDLE = 1'b0, WAVE_RUN = 1'b1} wave_st_e;
endpackage

// File: rtl/ring_seq_wave.sv
module ring_seq_wave
  import ring_seq_pkg::*;
#(
  parameter int CELLS = 1024,
  localparam int PW = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cont_mode,
  output logic          running,
  output logic [PW-1:0] cell_idx,
  output logic          tap,
  output logic          rev_end,
  output logic          run_fall
);
  localparam logic [PW-1:0] LAST = PW'(CELLS - 1);
  localparam logic [PW-1:0] MID  = PW'(CELLS / 2);

  wave_st_e      st_q, st_d;
  logic [PW-1:0] cell_q, cell_d;
  logic          tap_q, tap_d, run_q;
  logic          rise;

  assign rise     = run_en & ~run_q;
  assign run_fall = ~run_en & run_q;
  assign rev_end  = (st_q == WAVE_RUN) & run_en & (cell_q == LAST);

  always_comb begin
    st_d   = st_q;
    cell_d = cell_q;
    tap_d  = tap_q;
    if (rise) begin
      st_d   = WAVE_RUN;
      cell_d = '0;
    end else if (st_q == WAVE_RUN) begin
      if (!run_en) begin
        st_d = WAVE_IDLE;
      end else if (cell_q == LAST) begin
        if (cont_mode) cell_d = '0;
        else           st_d   = WAVE_IDLE;
      end else begin
        cell_d = cell_q + 1'b1;
        if (cell_d == MID) tap_d = ~tap_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WAVE_IDLE;
      cell_q <= '0;
      tap_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cell_q <= cell_d;
      tap_q  <= tap_d;
      run_q  <= run_en;
    end
  end

  assign running  = (st_q == WAVE_RUN);
  assign cell_idx = cell_q;
  assign tap      = tap_q;
endmodule

// File: rtl/ring_seq_chanreg.sv
module ring_seq_chanreg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           loop_sel,
  input  logic           chain_in,
  input  logic           act_load,
  input  logic [NCH-1:0] act_init,
  output logic [NCH-1:0] act,
  output logic           chain_out
);
  logic [NCH-1:0] act_q, act_d;
  logic           feed;

  assign feed = loop_sel ? act_q[NCH-1] : chain_in;

  always_comb begin
    act_d = act_q;
    if (act_load)      act_d = act_init;
    else if (shift_en) act_d = {act_q[NCH-2:0], feed};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '1;
    else        act_q <= act_d;
  end

  assign act       = act_q;
  assign chain_out = act_q[NCH-1];
endmodule

// File: rtl/ring_seq_guard.sv
module ring_seq_guard #(
  parameter int CELLS = 1024,
  parameter int GW    = 4,
  localparam int PW = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          wr_en,
  input  logic          run_fall,
  input  logic [GW-1:0] guard_cyc,
  input  logic [PW-1:0] cell_idx,
  output logic [PW-1:0] stop_pos,
  output logic          seq_err
);
  logic [PW-1:0] stop_q, stop_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          wr_q, err_q, err_d, capture;

  assign capture = running & wr_q & ~wr_en;

  always_comb begin
    stop_d = capture ? cell_idx : stop_q;
    if (wr_en)            gap_d = '0;
    else if (&gap_q)      gap_d = gap_q;
    else                  gap_d = gap_q + 1'b1;
    err_d = err_q | (running & run_fall & (wr_en | (gap_q < guard_cyc)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= '0;
      gap_q  <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      stop_q <= stop_d;
      gap_q  <= gap_d;
      wr_q   <= wr_en;
      err_q  <= err_d;
    end
  end

  assign stop_pos = stop_q;
  assign seq_err  = err_q;
endmodule

// File: rtl/ring_seq_top.sv
module ring_seq_top #(
  parameter int CELLS = 1024,
  parameter int NCH   = 8,
  parameter int GW    = 4,
  localparam int PW = $clog2(CELLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  logic           wr_en,
  input  logic           cont_mode,
  input  logic           loop_sel,
  input  logic           chain_in,
  input  logic           act_load,
  input  logic [NCH-1:0] act_init,
  input  logic [NCH-1:0] wcfg,
  input  logic [GW-1:0]  guard_cyc,
  output logic           running,
  output logic [PW-1:0]  cell_idx,
  output logic           tap,
  output logic [NCH:0]   ch_active,
  output logic           chain_out,
  output logic [PW-1:0]  stop_pos,
  output logic           seq_err
);
  logic           rev_end, run_fall, sampling;
  logic [NCH-1:0] act;

  ring_seq_wave #(.CELLS(CELLS)) u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cont_mode(cont_mode),
    .running(running), .cell_idx(cell_idx), .tap(tap),
    .rev_end(rev_end), .run_fall(run_fall)
  );

  ring_seq_chanreg #(.NCH(NCH)) u_chan (
    .clk(clk), .rst_n(rst_n), .shift_en(rev_end & wr_en),
    .loop_sel(loop_sel), .chain_in(chain_in), .act_load(act_load),
    .act_init(act_init), .act(act), .chain_out(chain_out)
  );

  ring_seq_guard #(.CELLS(CELLS), .GW(GW)) u_guard (
    .clk(clk), .rst_n(rst_n), .running(running), .wr_en(wr_en),
    .run_fall(run_fall), .guard_cyc(guard_cyc), .cell_idx(cell_idx),
    .stop_pos(stop_pos), .seq_err(seq_err)
  );

  assign sampling = running & wr_en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_active[g] = sampling & act[g] & wcfg[g];
  end
  assign ch_active[NCH] = sampling;
endmodule

// File: rtl/ring_seq_chk.sv
module ring_seq_chk #(
  parameter int CELLS = 1024,
  parameter int NCH   = 8,
  localparam int PW = $clog2(CELLS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          wr_en,
  input logic          cont_mode,
  input logic          running,
  input logic [PW-1:0] cell_idx,
  input logic          tap,
  input logic [NCH:0]  ch_active,
  input logic [PW-1:0] stop_pos,
  input logic          seq_err
);
  localparam logic [PW-1:0] LAST = PW'(CELLS - 1);
  localparam logic [PW-1:0] MID  = PW'(CELLS / 2);

  // R1
  cell_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_en && cell_idx != LAST) |=> (cell_idx == $past(cell_idx) + 1'b1));
  // R3
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_en && cont_mode && cell_idx == LAST) |=> (running && cell_idx == '0));
  // R3
  single_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_en && !cont_mode && cell_idx == LAST) |=> (!running && cell_idx == LAST));
  // R2
  tap_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap) |-> (cell_idx == MID && running));
  // R4
  ninth_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_active[NCH-1:0]) |-> ch_active[NCH]);
  // R8
  stop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(wr_en) && !wr_en) |=> (stop_pos == $past(cell_idx)));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);
endmodule

bind ring_seq_top ring_seq_chk #(.CELLS(CELLS), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
  .cont_mode(cont_mode), .running(running), .cell_idx(cell_idx),
  .tap(tap), .ch_active(ch_active), .stop_pos(stop_pos), .seq_err(seq_err)
);

// File: tb/tb_ring_seq_top.sv
module tb_ring_seq_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en, wr_en, cont_mode, loop_sel, chain_in, act_load;
  logic [7:0] act_init, wcfg;
  logic [3:0] guard_cyc;
  logic       running, tap, chain_out, seq_err;
  logic [9:0] cell_idx, stop_pos;
  logic [8:0] ch_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ring_seq_top dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .cont_mode(cont_mode), .loop_sel(loop_sel), .chain_in(chain_in),
    .act_load(act_load), .act_init(act_init), .wcfg(wcfg),
    .guard_cyc(guard_cyc), .running(running), .cell_idx(cell_idx),
    .tap(tap), .ch_active(ch_active), .chain_out(chain_out),
    .stop_pos(stop_pos), .seq_err(seq_err)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act_v, exp_v);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run_en = 0; wr_en = 0; cont_mode = 1; loop_sel = 1;
    chain_in = 0; act_load = 0; act_init = '0; wcfg = 8'hFF; guard_cyc = 4'd4;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 running", running, 0);
    check("R10 cell", cell_idx, 0);
    check("R10 stop", stop_pos, 0);
    check("R10 err", seq_err, 0);
    check("R10 ch_active", ch_active, 0);
    check("R10 chain_out", chain_out, 1);
    check("R2 tap reset", tap, 0);
  endtask

  task automatic t_continuous();
    act_load = 1; act_init = 8'h01; loop_sel = 1; cont_mode = 1; wr_en = 1;
    step(1);
    act_load = 0; run_en = 1;
    step(1);
    check("R1 start running", running, 1);
    check("R1 start cell", cell_idx, 0);
    check("R4 first cell active", ch_active, 9'h101);
    step(511);
    check("R1 advance", cell_idx, 511);
    check("R2 tap before mid", tap, 0);
    step(1);
    check("R2 cell mid", cell_idx, 512);
    check("R2 tap toggled", tap, 1);
    step(511);
    check("R3 last cell", cell_idx, 1023);
    check("R4 before shift", ch_active, 9'h101);
    step(1);
    check("R3 wrap to 0", cell_idx, 0);
    check("R5 shifted once", ch_active, 9'h102);
    check("R6 chain_out", chain_out, 0);
  endtask

  task automatic t_stop_and_guard_ok();
    step(100);
    check("R1 cell 100", cell_idx, 100);
    wr_en = 0;
    step(1);
    check("R8 stop latched", stop_pos, 100);
    check("R4 write low idle", ch_active, 0);
    step(923);
    check("R3 wrap again", cell_idx, 0);
    check("R2 tap second toggle", tap, 0);
    wr_en = 1;
    step(1);
    check("R5 no shift while write low", ch_active, 9'h102);
    wr_en = 0;
    step(10);
    run_en = 0;
    step(1);
    check("R1 stop running", running, 0);
    check("R1 cell held", cell_idx, 11);
    check("R9 no error with gap", seq_err, 0);
    step(5);
    check("R1 still held", cell_idx, 11);
    check("R8 stop value", stop_pos, 1);
  endtask

  task automatic t_guard_violation();
    wr_en = 1; run_en = 1;
    step(1);
    check("R1 restart cell", cell_idx, 0);
    step(20);
    wr_en = 0;
    step(2);
    run_en = 0;
    step(1);
    check("R9 short gap error", seq_err, 1);
    step(3);
    check("R9 error sticky", seq_err, 1);
  endtask

  task automatic t_single_shot();
    do_reset();
    cont_mode = 0; loop_sel = 0; chain_in = 0; guard_cyc = 0;
    act_load = 1; act_init = 8'h80; wcfg = 8'h0F;
    step(1);
    act_load = 0; run_en = 1; wr_en = 1;
    step(1);
    check("R4 masked and ninth", ch_active, 9'h100);
    check("R6 chain_out high", chain_out, 1);
    step(1023);
    check("R3 single reach last", cell_idx, 1023);
    check("R3 single still running", running, 1);
    step(1);
    check("R3 single halted", running, 0);
    check("R3 single cell held", cell_idx, 1023);
    check("R6 chain_in fed", chain_out, 0);
    step(600);
    check("R3 single one tap rise", tap, 1);
    check("R3 single idle cell", cell_idx, 1023);
    check("R4 halted inactive", ch_active, 0);
  endtask

  task automatic t_load_vs_shift();
    do_reset();
    cont_mode = 1; loop_sel = 1; wr_en = 1; act_load = 1; act_init = 8'h01;
    step(1);
    act_load = 0; run_en = 1;
    step(1024);
    check("R7 at last cell", cell_idx, 1023);
    act_load = 1; act_init = 8'h30;
    step(1);
    act_load = 0;
    check("R7 load beats shift", ch_active, 9'h130);
    step(1024);
    check("R5 later shift", ch_active, 9'h160);
    act_load = 1; act_init = 8'h80;
    step(1);
    act_load = 0;
    step(1023);
    check("R6 loop feeds bit7", ch_active, 9'h101);
  endtask

  initial begin
    t_reset();
    t_continuous();
    t_stop_and_guard_ok();
    t_guard_violation();
    t_single_shot();
    t_load_vs_shift();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule